// File: doc/BRIEF.md
# Serial Flash Programming Host Sequencer

This block is the host side of a four-byte serial programming link to a microcontroller target. It owns the target's reset line and the serial clock, drives the host-to-target data line and reads the target-to-host data line. A single `start` strobe runs one whole session. The sequencer first applies a reset pulse with the clock held low and waits out the target's start-up time. It then sends the programming-enable instruction and checks the target's echo of the synchronization byte, retrying through a fresh reset pulse when the echo is wrong. After that it fills and commits consecutive flash pages, and finally releases the target into normal operation.

Program words arrive on a ready/valid stream, one 16-bit word per handshake, and the sequencer stalls between instructions whenever no word is offered. The number of pages and the first page number are sampled at `start`. The end of a session shows on `done`, or on `error` when synchronization was never reached.

Top module: `isp_host_seq`

## Requirements
- R1: While `rst_n` is low and right after it rises, `sck`, `mosi`, `tgt_reset`, `word_ready`, `busy`, `done` and `error` are all 0.
- R2: On `start` in idle, `tgt_reset` goes high with `sck` low and stays high for at least RST_CYC clock cycles before it falls. Every synchronization retry repeats this pulse, and `sck` is never high while `tgt_reset` is high.
- R3: After each falling edge of `tgt_reset`, at least PWRUP_CYC clock cycles pass before the first rising edge of `sck`.
- R4: Each instruction is 32 bits, sent MSB first with no gap between bytes. Each `sck` low and high phase lasts exactly HALF_CYC cycles (HALF_CYC at least 3). `mosi` only changes while `sck` is low. `miso` is sampled at the end of each low phase, which comes after the target's falling-edge update.
- R5: The enable instruction is the bytes 0xAC 0x53 0x00 0x00. All four bytes are always sent, and synchronization holds when the byte received during the third byte equals 0x53.
- R6: On a wrong echo, the sequencer pulses reset, waits again and reissues the enable instruction. After MAX_TRIES wrong echoes in a row, `error` goes to 1, `done` stays 0, `tgt_reset` is left high, and no further `sck` edge occurs.
- R7: Each word taken from the stream (`word_valid` and `word_ready` both high on a clock edge) produces a low-byte load 0x40 0x00 idx lo, followed by a high-byte load 0x48 0x00 idx hi. Here idx is the word's index within the page (5 bits at the default of 32 words). `word_ready` is high only while the sequencer waits for a word, and no `sck` edge occurs while it waits.
- R8: After PAGE_WORDS words, a page-write instruction 0x4C A[15:8] A[7:0] 0x00 is sent. A is the word address of the page: the page number shifted left by log2(PAGE_WORDS).
- R9: After a page-write instruction, at least WRITE_CYC clock cycles pass before the next `sck` rising edge.
- R10: Pages are `n_pages` consecutive numbers starting at `page_addr`, wrapping modulo 2^PG_W. With `n_pages` = 0, only the enable handshake is done. At the end, `tgt_reset` goes high, `done` goes to 1 and `busy` to 0.
- R11: `start` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a session (idle only) |
| page_addr | input | PG_W | First page number, sampled at start |
| n_pages | input | NP_W | Pages to program, sampled at start |
| word_valid | input | 1 | Program word offered |
| word_ready | output | 1 | Sequencer waiting for a word |
| word_data | input | 16 | Program word, low byte in [7:0] |
| sck | output | 1 | Serial clock to target |
| mosi | output | 1 | Serial data to target |
| tgt_reset | output | 1 | Target reset line, high = held in reset |
| miso | input | 1 | Serial data from target |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished successfully |
| error | output | 1 | Synchronization retries exhausted |

## Verification
A wrong state or counter inside the sequencer becomes visible at the latest on the next 32-bit instruction. The decoded instruction then has the wrong opcode, word index, address or byte order, or it shows up where the scoreboard expects none. A phase counter that runs off shows on the next `sck` half period. A retry counter off by one changes the number of enable instructions before `error` or before the first page load. A lost wait count shows as a reset pulse, a start-up gap or a post-write gap that is shorter than required, measured from one pin edge to the next.

// File: rtl/isp_host_seq.sv
module isp_host_seq #(
  parameter int HALF_CYC   = 4,
  parameter int RST_CYC    = 4,
  parameter int PWRUP_CYC  = 2_500_000,
  parameter int WRITE_CYC  = 562_500,
  parameter int PAGE_WORDS = 32,
  parameter int PG_W       = 7,
  parameter int MAX_TRIES  = 4,
  parameter int NP_W       = 8
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PG_W-1:0] page_addr,
  input  logic [NP_W-1:0] n_pages,
  input  logic            word_valid,
  output logic            word_ready,
  input  logic [15:0]     word_data,
  output logic            sck,
  output logic            mosi,
  output logic            tgt_reset,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic            error
);
  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_PWAIT, S_GET, S_XFER, S_EVAL, S_WWAIT} st_t;
  typedef enum logic [1:0] {K_EN, K_LO, K_HI, K_WR} kind_t;

  localparam int WB    = $clog2(PAGE_WORDS);
  localparam int AW    = PG_W + WB;
  localparam int TA    = (PWRUP_CYC > WRITE_CYC) ? PWRUP_CYC : WRITE_CYC;
  localparam int TB    = (HALF_CYC > RST_CYC) ? HALF_CYC : RST_CYC;
  localparam int TMAX  = (TA > TB) ? TA : TB;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [7:0]  SYNC_ECHO = 8'h53;
  localparam logic [31:0] EN_INSTR  = 32'hAC53_0000;
  localparam logic [TMR_W-1:0] T_HALF = TMR_W'(HALF_CYC - 1);
  localparam logic [TMR_W-1:0] T_RST  = TMR_W'(RST_CYC - 1);
  localparam logic [TMR_W-1:0] T_PWR  = TMR_W'(PWRUP_CYC - 1);
  localparam logic [TMR_W-1:0] T_WR   = TMR_W'(WRITE_CYC - 1);
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);
  localparam logic [WB-1:0]    LAST_W   = WB'(PAGE_WORDS - 1);

  st_t              st;
  kind_t            kind;
  logic [TMR_W-1:0] tmr;
  logic [4:0]       bitn;
  logic [31:0]      txsr;
  logic [7:0]       rxsr, echo;
  logic [TRY_W-1:0] tries;
  logic [PG_W-1:0]  page;
  logic [NP_W-1:0]  left;
  logic [WB-1:0]    widx;
  logic [15:0]      wd;
  logic [AW-1:0]    wa;
  logic [15:0]      wa16;
  logic             tz;

  assign wa         = {page, {WB{1'b0}}};
  assign wa16       = 16'(wa);
  assign tz         = (tmr == '0);
  assign word_ready = (st == S_GET);
  assign busy       = (st != S_IDLE);
  assign mosi       = (st == S_XFER) & txsr[31];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_EN; tmr <= '0; bitn <= '0; txsr <= '0;
      rxsr <= '0; echo <= '0; tries <= '0; page <= '0; left <= '0;
      widx <= '0; wd <= '0; sck <= 1'b0; tgt_reset <= 1'b0;
      done <= 1'b0; error <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          done <= 1'b0; error <= 1'b0; tries <= '0;
          page <= page_addr; left <= n_pages; widx <= '0;
          tgt_reset <= 1'b1; tmr <= T_RST; st <= S_PULSE;
        end
        S_PULSE: if (tz) begin
          tgt_reset <= 1'b0; tmr <= T_PWR; st <= S_PWAIT;
        end else tmr <= tmr - 1'b1;
        S_PWAIT: if (tz) begin
          txsr <= EN_INSTR; kind <= K_EN; bitn <= '0; tmr <= T_HALF; st <= S_XFER;
        end else tmr <= tmr - 1'b1;
        S_GET: if (word_valid) begin
          wd <= word_data;
          txsr <= {8'h40, 8'h00, 8'(widx), word_data[7:0]};
          kind <= K_LO; bitn <= '0; tmr <= T_HALF; st <= S_XFER;
        end
        S_XFER: if (!tz) tmr <= tmr - 1'b1;
        else begin
          tmr <= T_HALF;
          if (!sck) begin
            sck  <= 1'b1;
            rxsr <= {rxsr[6:0], miso};
            if (bitn == 5'd23) echo <= {rxsr[6:0], miso};
          end else begin
            sck  <= 1'b0;
            txsr <= {txsr[30:0], 1'b0};
            bitn <= bitn + 1'b1;
            if (bitn == 5'd31) st <= S_EVAL;
          end
        end
        S_EVAL: case (kind)
          K_EN: if (echo == SYNC_ECHO) begin
            if (left == '0) begin
              tgt_reset <= 1'b1; done <= 1'b1; st <= S_IDLE;
            end else st <= S_GET;
          end else if (tries == LAST_TRY) begin
            error <= 1'b1; tgt_reset <= 1'b1; st <= S_IDLE;
          end else begin
            tries <= tries + 1'b1; tgt_reset <= 1'b1; tmr <= T_RST; st <= S_PULSE;
          end
          K_LO: begin
            txsr <= {8'h48, 8'h00, 8'(widx), wd[15:8]};
            kind <= K_HI; tmr <= T_HALF; st <= S_XFER;
          end
          K_HI: if (widx == LAST_W) begin
            txsr <= {8'h4C, wa16[15:8], wa16[7:0], 8'h00};
            kind <= K_WR; tmr <= T_HALF; st <= S_XFER;
          end else begin
            widx <= widx + 1'b1; st <= S_GET;
          end
          default: begin tmr <= T_WR; st <= S_WWAIT; end
        endcase
        S_WWAIT: if (tz) begin
          widx <= '0; page <= page + 1'b1; left <= left - 1'b1;
          if (left == NP_W'(1)) begin
            tgt_reset <= 1'b1; done <= 1'b1; st <= S_IDLE;
          end else st <= S_GET;
        end else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  initial a_r4_half_min: assert (HALF_CYC >= 3);

  a_r2_sck_low_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_reset |-> !sck);
  a_r4_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  a_r7_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> (!sck && !tgt_reset && !mosi));
  a_r10_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tgt_reset && !busy));
  a_r6_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!done && tgt_reset));
  a_r4_sck_fall_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |=> !sck);
endmodule

// File: tb/tb_isp_host_seq.sv
`timescale 1ns/1ps
module tb_isp_host_seq;
  localparam int HALF = 3, RST = 4, PWR = 200, WRC = 100, PW = 4, PGW = 7, MT = 3, NPW = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [PGW-1:0] page_addr = '0;
  logic [NPW-1:0] n_pages = '0;
  logic word_valid = 0;
  logic [15:0] word_data = '0;
  logic word_ready, sck, mosi, tgt_reset, busy, done, error;
  logic miso = 0;

  isp_host_seq #(.HALF_CYC(HALF), .RST_CYC(RST), .PWRUP_CYC(PWR), .WRITE_CYC(WRC),
    .PAGE_WORDS(PW), .PG_W(PGW), .MAX_TRIES(MT), .NP_W(NPW)) dut (
    .clk, .rst_n, .start, .page_addr, .n_pages, .word_valid, .word_ready, .word_data,
    .sck, .mosi, .tgt_reset, .miso, .busy, .done, .error);

  always #4 clk = ~clk;

  int nvec = 0, nbad = 0;
  logic [31:0] expq[$];
  logic [15:0] wq[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin nbad++; $display("FAIL %s: got %h expected %h", req, act, exp); end
  endtask

  function automatic longint now_c(); return longint'($time / 8); endfunction

  // target model
  int bad_left = 0, t_bc = 0;
  logic [31:0] t_sr = '0;
  logic [7:0] echo_b = '0;
  always @(posedge sck) begin
    t_sr = {t_sr[30:0], mosi};
    t_bc = t_bc + 1;
    if (t_bc == 16) begin
      if (t_sr[15:8] == 8'hAC && bad_left > 0) begin echo_b = 8'h00; bad_left--; end
      else echo_b = t_sr[7:0];
    end
    if (t_bc == 32) t_bc = 0;
  end
  always @(negedge sck) if (t_bc >= 16 && t_bc < 24) miso <= echo_b[23 - t_bc];
  always @(posedge tgt_reset) t_bc = 0;

  // monitor / scoreboard
  int m_bc = 0, rises = 0;
  logic [31:0] m_sr = '0;
  longint last_rise = 0, last_fall = 0, r_rise = 0, r_fall = 0;
  bit after_rst = 0, after_wr = 0;
  always @(posedge sck) begin
    rises++;
    if (m_bc == 0) begin
      if (after_rst) begin chk(now_c() - r_fall >= PWR, "R3 startup gap", 32'(now_c() - r_fall), PWR); after_rst = 0; end
      if (after_wr) begin chk(now_c() - last_fall >= WRC, "R9 write gap", 32'(now_c() - last_fall), WRC); after_wr = 0; end
    end else chk(now_c() - last_fall == HALF, "R4 low phase", 32'(now_c() - last_fall), HALF);
    last_rise = now_c();
    m_sr = {m_sr[30:0], mosi};
    m_bc++;
    if (m_bc == 32) begin
      m_bc = 0;
      if (expq.size() == 0) chk(0, "R6/R10 unexpected instruction", m_sr, 32'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(m_sr == e, "R5/R7/R8 instruction", m_sr, e);
      end
      after_wr = (m_sr[31:24] == 8'h4C);
    end
  end
  always @(negedge sck) begin
    chk(now_c() - last_rise == HALF, "R4 high phase", 32'(now_c() - last_rise), HALF);
    last_fall = now_c();
  end
  always @(posedge tgt_reset) begin
    chk(sck == 1'b0, "R2 sck low at reset", 32'(sck), 0);
    r_rise = now_c(); m_bc = 0;
  end
  always @(negedge tgt_reset) begin
    chk(now_c() - r_rise >= RST, "R2 reset width", 32'(now_c() - r_rise), RST);
    r_fall = now_c(); after_rst = 1;
  end

  // word feeder with stalls
  int stall = 0, fed = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (wq.size() > 0 && stall == 0) begin word_valid = 1; word_data = wq[0]; end
      else word_valid = 0;
      if (word_valid && word_ready) begin
        @(posedge clk);
        void'(wq.pop_front());
        fed++;
        stall = (fed % 3) * 40;
      end else if (stall > 0) stall--;
    end
  end

  function automatic logic [15:0] wgen(int p, int w);
    return {8'(p) ^ 8'h3C, 8'(w * 7 + 33)};
  endfunction

  task automatic plan_session(int pg, int np, int bad, bit err);
    int p;
    bad_left = bad;
    for (int i = 0; i < (err ? MT : bad + 1); i++) expq.push_back(32'hAC53_0000);
    if (!err) begin
      p = pg;
      for (int k = 0; k < np; k++) begin
        logic [15:0] a;
        for (int w = 0; w < PW; w++) begin
          logic [15:0] d;
          d = wgen(p, w);
          wq.push_back(d);
          expq.push_back({8'h40, 8'h00, 8'(w), d[7:0]});
          expq.push_back({8'h48, 8'h00, 8'(w), d[15:8]});
        end
        a = 16'(p * PW);
        expq.push_back({8'h4C, a[15:8], a[7:0], 8'h00});
        p = (p + 1) % (1 << PGW);
      end
    end
  endtask

  task automatic kick(int pg, int np);
    @(negedge clk); page_addr = PGW'(pg); n_pages = NPW'(np); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end(output bit ok);
    ok = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done || error) begin ok = 1; break; end
    end
  endtask

  task automatic end_checks(string req, bit exp_err);
    chk(done == !exp_err, {req, " done"}, 32'(done), 32'(!exp_err));
    chk(error == exp_err, {req, " error"}, 32'(error), 32'(exp_err));
    chk(tgt_reset && !busy, {req, " reset released high"}, {tgt_reset, busy}, 2'b10);
    chk(expq.size() == 0, {req, " instructions left"}, expq.size(), 0);
    chk(wq.size() == 0, {req, " words left"}, wq.size(), 0);
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    bit ok;
    int r0;
    repeat (5) @(negedge clk);
    chk({sck, mosi, tgt_reset, word_ready, busy, done, error} == 0, "R1 in reset",
        {sck, mosi, tgt_reset, word_ready, busy, done, error}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({sck, mosi, tgt_reset, word_ready, busy, done, error} == 0, "R1 after reset",
        {sck, mosi, tgt_reset, word_ready, busy, done, error}, 0);

    // two failed syncs, two pages, mid-session start ignored (R6, R7, R8, R11)
    plan_session(5, 2, 2, 0);
    kick(5, 2);
    repeat (1500) @(negedge clk);
    chk(busy == 1, "R11 busy before restart", 32'(busy), 1);
    kick(20, 1);
    wait_end(ok);
    chk(ok, "R10 session ends", 32'(ok), 1);
    end_checks("R10", 0);

    // sync never reached (R6)
    plan_session(0, 1, MT, 1);
    kick(0, 1);
    wait_end(ok);
    chk(ok, "R6 session ends", 32'(ok), 1);
    r0 = rises;
    repeat (400) @(negedge clk);
    chk(rises == r0, "R6 no clock after error", rises, r0);
    end_checks("R6", 1);

    // page wrap at top page (R10, R8)
    plan_session(127, 2, 0, 0);
    kick(127, 2);
    wait_end(ok);
    chk(ok, "R10 wrap session ends", 32'(ok), 1);
    end_checks("R10 wrap", 0);

    // zero pages: handshake only (R10, R5)
    plan_session(9, 0, 0, 0);
    kick(9, 0);
    wait_end(ok);
    chk(ok, "R10 empty session ends", 32'(ok), 1);
    end_checks("R10 empty", 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule